// File: doc/BRIEF.md
# Load/Store Alignment and Stack Bounds Guard

This block sits beside a processor's load/store path and inspects every data access address one cycle before the access is allowed to proceed. It performs two checks. The first is a natural-alignment test for halfword and word accesses. The second applies only to stack-relative accesses and tests the address against a programmable window given by a lower and an upper bound.

When a check fails, the block records the offending address in a capture register. It also composes an exception status word that encodes the cause and, for alignment faults, the access direction, the destination register index and whether the access was word sized. Finally it produces a single-cycle exception request that downstream vectoring logic consumes.

Alignment faults always update the capture registers, but they request an exception only while the global exception enable is set. Stack window faults request an exception regardless of that enable. When both checks fail on one access, the alignment report wins.

Top module: `access_guard_top`

## Requirements
- R1: While `rst` is high on a clock edge, `exc_req`, `fault_addr` and `fault_status` are cleared to zero by that edge.
- R2: An access with `acc_valid` high is misaligned when `acc_addr & acc_size_mask` is nonzero. Masks are 0 for bytes, 1 for halfwords and 3 for words. On the edge that samples a misaligned access, `fault_addr` takes `acc_addr` and `fault_status[4:0]` takes the alignment cause code 5'h01.
- R3: The alignment status word has fixed fields: bit 10 holds `acc_write`, bits 9..5 hold `acc_reg`, bit 11 is 1 exactly when `acc_size_mask` equals 3, and bits 31..12 are 0.
- R4: On a misaligned access, `exc_req` goes high on the following cycle only if `exc_enable` was high with the access. `fault_addr` and `fault_status` are updated either way.
- R5: A valid access with `acc_stack` high violates the stack window when `acc_addr < bound_lo` or `acc_addr > bound_hi`, compared unsigned. An address equal to either bound is legal.
- R6: On a stack window violation without misalignment, the next cycle shows `fault_addr` equal to the address, `fault_status` equal to exactly 32'h0000_0007, and `exc_req` high whatever `exc_enable` is.
- R7: If one access is both misaligned and outside the stack window, only the alignment report of R2 to R4 is produced, including its dependence on `exc_enable`.
- R8: A cycle with `acc_valid` low, or with a valid access that fails neither check, leaves `fault_addr` and `fault_status` unchanged and gives `exc_req` low on the next cycle.
- R9: With `acc_stack` low, an address outside the window raises no stack fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_size_mask | input | 2 | Low-address mask: 0 byte, 1 halfword, 3 word |
| acc_write | input | 1 | 1 for store, 0 for load |
| acc_reg | input | 5 | Destination or source register index |
| acc_stack | input | 1 | Access is stack-relative, apply window check |
| bound_lo | input | 32 | Lowest legal stack address (inclusive) |
| bound_hi | input | 32 | Highest legal stack address (inclusive) |
| exc_enable | input | 1 | Global exception enable (gates alignment faults only) |
| exc_req | output | 1 | One-cycle exception request |
| fault_addr | output | 32 | Captured faulting address |
| fault_status | output | 32 | Exception status word |

## Verification
A wrong priority or a stale capture register shows on `fault_addr` and `fault_status` one cycle after the offending access, and it persists until the next fault overwrites it. A field packed at the wrong position, or a missing word-size bit, is visible in the status word on that same cycle. A gate on the request that is applied to the wrong cause shows as a missing or extra `exc_req` pulse, also exactly one cycle after the access. For that reason every access is checked on the cycle that follows it, and no fault is left to surface later.

// File: rtl/access_guard_pkg.sv
package access_guard_pkg;
  localparam int unsigned STATUS_W   = 32;
  localparam int unsigned CAUSE_W    = 5;
  localparam int unsigned REG_W      = 5;
  localparam int unsigned REG_LSB    = 5;
  localparam int unsigned WRITE_BIT  = 10;
  localparam int unsigned WORD_BIT   = 11;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE      = 5'h00,
    CAUSE_UNALIGNED = 5'h01,
    CAUSE_STACK     = 5'h07
  } cause_e;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_ALIGN = 2'd1,
    SEL_STACK = 2'd2
  } report_sel_e;
endpackage

// File: rtl/guard_align_unit.sv
module guard_align_unit
  import access_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 2
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [MASK_W-1:0]   size_mask,
  input  logic                is_write,
  input  logic [REG_W-1:0]    reg_idx,
  output logic                misaligned,
  output logic [STATUS_W-1:0] status_word
);
  localparam logic [MASK_W-1:0] WORD_MASK = MASK_W'(3);

  logic [MASK_W-1:0] low_bits;
  assign low_bits   = addr[MASK_W-1:0] & size_mask;
  assign misaligned = |low_bits;

  always_comb begin
    status_word                          = '0;
    status_word[CAUSE_W-1:0]             = CAUSE_UNALIGNED;
    status_word[REG_LSB +: REG_W]        = reg_idx;
    status_word[WRITE_BIT]               = is_write;
    status_word[WORD_BIT]                = (size_mask == WORD_MASK);
  end
endmodule

// File: rtl/guard_bound_unit.sv
module guard_bound_unit #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              check_en,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              below,
  output logic              above,
  output logic              violation
);
  assign below     = addr < lo;
  assign above     = addr > hi;
  assign violation = check_en & (below | above);
endmodule

// File: rtl/guard_fault_regs.sv
module guard_fault_regs
  import access_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                align_fail,
  input  logic [STATUS_W-1:0] align_status,
  input  logic                stack_fail,
  input  logic                exc_enable,
  output logic                exc_req,
  output logic [ADDR_W-1:0]   fault_addr,
  output logic [STATUS_W-1:0] fault_status
);
  report_sel_e         sel;
  logic [STATUS_W-1:0] next_status;
  logic                next_req;

  always_comb begin
    sel = SEL_NONE;
    if (valid && align_fail)      sel = SEL_ALIGN;
    else if (valid && stack_fail) sel = SEL_STACK;
  end

  always_comb begin
    next_status = fault_status;
    next_req    = 1'b0;
    case (sel)
      SEL_ALIGN: begin
        next_status = align_status;
        next_req    = exc_enable;
      end
      SEL_STACK: begin
        next_status              = '0;
        next_status[CAUSE_W-1:0] = CAUSE_STACK;
        next_req                 = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_req      <= 1'b0;
      fault_addr   <= '0;
      fault_status <= '0;
    end else begin
      exc_req      <= next_req;
      fault_status <= next_status;
      if (sel != SEL_NONE) fault_addr <= addr;
    end
  end

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> ($stable(fault_addr) && $stable(fault_status) && !exc_req));
  a_r6_stack_ignores_enable: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_STACK) |=> (exc_req && fault_status[CAUSE_W-1:0] == CAUSE_STACK));
endmodule

// File: rtl/access_guard_top.sv
module access_guard_top
  import access_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [MASK_W-1:0] acc_size_mask,
  input  logic              acc_write,
  input  logic [4:0]        acc_reg,
  input  logic              acc_stack,
  input  logic [ADDR_W-1:0] bound_lo,
  input  logic [ADDR_W-1:0] bound_hi,
  input  logic              exc_enable,
  output logic              exc_req,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [31:0]       fault_status
);
  logic                misaligned;
  logic [STATUS_W-1:0] align_status;
  logic                below, above, stack_viol;

  guard_align_unit #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_align (
    .addr(acc_addr), .size_mask(acc_size_mask), .is_write(acc_write),
    .reg_idx(acc_reg), .misaligned(misaligned), .status_word(align_status)
  );

  guard_bound_unit #(.ADDR_W(ADDR_W)) u_bound (
    .addr(acc_addr), .check_en(acc_stack), .lo(bound_lo), .hi(bound_hi),
    .below(below), .above(above), .violation(stack_viol)
  );

  guard_fault_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .valid(acc_valid), .addr(acc_addr),
    .align_fail(misaligned), .align_status(align_status),
    .stack_fail(stack_viol), .exc_enable(exc_enable),
    .exc_req(exc_req), .fault_addr(fault_addr), .fault_status(fault_status)
  );

  a_r2_capture_on_misalign: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && misaligned) |=> (fault_addr == $past(acc_addr) && fault_status[4:0] == 5'h01));
  a_r4_request_follows_enable: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && misaligned) |=> (exc_req == $past(exc_enable)));
  a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
    fault_status[31:12] == 20'h0);
  a_r9_no_stack_fault_unchecked: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_stack && !misaligned) |=> !exc_req);
  a_r7_align_wins: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && misaligned && stack_viol) |=> (fault_status[4:0] == 5'h01));
endmodule

// File: tb/sim_access_guard_top.sv
module sim_access_guard_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_write, acc_stack, exc_enable;
  logic [31:0] acc_addr, bound_lo, bound_hi;
  logic [1:0]  acc_size_mask;
  logic [4:0]  acc_reg;
  logic        exc_req;
  logic [31:0] fault_addr, fault_status;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] m_addr, m_status;
  logic        m_req;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  access_guard_top u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size_mask(acc_size_mask), .acc_write(acc_write), .acc_reg(acc_reg),
    .acc_stack(acc_stack), .bound_lo(bound_lo), .bound_hi(bound_hi),
    .exc_enable(exc_enable), .exc_req(exc_req), .fault_addr(fault_addr),
    .fault_status(fault_status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] align_word(input logic w, input logic [4:0] r, input logic [1:0] m);
    return {20'h0, (m == 2'd3), w, r, 5'h01};
  endfunction

  // Model update per requirements R2..R9
  task automatic model(input logic v, input logic [31:0] a, input logic [1:0] m, input logic w,
                       input logic [4:0] r, input logic s, input logic [31:0] lo,
                       input logic [31:0] hi, input logic en);
    logic mis, stk;
    mis = v && ((a[1:0] & m) != 2'b0);
    stk = v && s && (a < lo || a > hi);
    m_req = 1'b0;
    if (mis) begin
      m_addr = a; m_status = align_word(w, r, m); m_req = en;
    end else if (stk) begin
      m_addr = a; m_status = 32'h7; m_req = 1'b1;
    end
  endtask

  task automatic access(input string req, input logic v, input logic [31:0] a, input logic [1:0] m,
                        input logic w, input logic [4:0] r, input logic s,
                        input logic [31:0] lo, input logic [31:0] hi, input logic en);
    acc_valid = v; acc_addr = a; acc_size_mask = m; acc_write = w; acc_reg = r;
    acc_stack = s; bound_lo = lo; bound_hi = hi; exc_enable = en;
    model(v, a, m, w, r, s, lo, hi, en);
    @(posedge clk);
    @(negedge clk);
    check({req, " req"},    {31'h0, exc_req}, {31'h0, m_req});
    check({req, " addr"},   fault_addr, m_addr);
    check({req, " status"}, fault_status, m_status);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; acc_valid = 0; acc_addr = 32'hFFFF_FFFF; acc_size_mask = 3; acc_write = 1;
    acc_reg = 5'h1F; acc_stack = 1; bound_lo = 32'h100; bound_hi = 32'h200; exc_enable = 1;
    m_addr = 0; m_status = 0; m_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 req",    {31'h0, exc_req}, 32'h0);
    check("R1 addr",   fault_addr, 32'h0);
    check("R1 status", fault_status, 32'h0);
    rst = 1'b0;

    // R2 R3 R4: word misaligned store, enabled
    access("R2 R3 word store",  1, 32'h0000_1002, 2'd3, 1, 5'd17, 0, 0, 0, 1);
    // R3: halfword load, bit11 clear
    access("R3 half load",      1, 32'h0000_2001, 2'd1, 0, 5'd3,  0, 0, 0, 1);
    // R4: disabled, registers still update, no request
    access("R4 disabled",       1, 32'hABCD_0003, 2'd3, 1, 5'd31, 0, 0, 0, 0);
    // R8: aligned word, registers hold
    access("R8 aligned",        1, 32'h0000_0004, 2'd3, 0, 5'd2,  0, 0, 0, 1);
    // R8: halfword at odd-by-two is aligned
    access("R8 half aligned",   1, 32'h0000_0006, 2'd1, 0, 5'd2,  0, 0, 0, 1);
    // R8: byte never misaligned
    access("R8 byte",           1, 32'h0000_0007, 2'd0, 1, 5'd2,  0, 0, 0, 1);
    // R8: invalid misaligned access ignored
    access("R8 invalid",        0, 32'h0000_0003, 2'd3, 1, 5'd9,  1, 32'h10, 32'h20, 1);
    // R5 R6: below window, enable off still requests
    access("R6 below",          1, 32'h0000_00FC, 2'd3, 0, 5'd4,  1, 32'h100, 32'h1FC, 0);
    // R5 R6: above window
    access("R6 above",          1, 32'h0000_0200, 2'd3, 1, 5'd4,  1, 32'h100, 32'h1FC, 1);
    // R5: both bounds inclusive
    access("R5 at lo",          1, 32'h0000_0100, 2'd3, 0, 5'd4,  1, 32'h100, 32'h1FC, 1);
    access("R5 at hi",          1, 32'h0000_01FC, 2'd3, 0, 5'd4,  1, 32'h100, 32'h1FC, 1);
    // R9: unchecked access out of window
    access("R9 unchecked",      1, 32'h0000_9000, 2'd3, 0, 5'd4,  0, 32'h100, 32'h1FC, 1);
    // R7: both fail, alignment wins, enable off -> no request
    access("R7 both dis",       1, 32'h0000_0001, 2'd1, 1, 5'd12, 1, 32'h100, 32'h1FC, 0);
    access("R7 both en",        1, 32'hFFFF_FFFE, 2'd3, 0, 5'd21, 1, 32'h100, 32'h1FC, 1);
    // back-to-back pulse ends (R8)
    access("R8 idle after",     0, 32'h0, 2'd0, 0, 5'd0, 0, 0, 0, 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] lo, a;
      lo = 32'h1000 + ($urandom % 64) * 4;
      a  = 32'h0FF0 + ($urandom % 400);
      access("R2-mix R5-mix random", ($urandom % 8) != 0, a, 2'($urandom % 4 == 2 ? 0 : $urandom % 4),
             1'($urandom), 5'($urandom), 1'($urandom), lo, lo + 32'h80 + ($urandom % 64), 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule